// File: doc/BRIEF.md
# Breakpoint Access-Type Qualifier

This block decides, every clock cycle, whether the first address-breakpoint comparator of a debug unit fires. A 2-bit selection field picks which bus and which class of transaction is watched. A 2-bit enable field picks reads, writes or both. Each cycle the core presents tags for the program-bus transaction and for the transaction on the first data address bus. The block checks these tags against the selected mode and compares each bus address for exact equality with a breakpoint address register.

When a transaction qualifies, the block raises a trigger pulse one cycle later. It also drives a global enable that every other breakpoint comparator uses. That enable goes low only when the enable field is zero. The selection field and the nonzero enable codes have no effect on the other comparators.

The data-bus tag port exists only for the first data address bus. The second data address bus, which serves the second read of a dual-read instruction, has no input here and can never cause a breakpoint.

Top module: `bkpt_qualifier`

## Requirements
- R1: When the enable field is 2'b00, the trigger never fires, whatever the selection field holds, and `glob_en_o` is 0. For any nonzero enable code, `glob_en_o` is 1 in the same cycle.
- R2: Selection 2'b00 with enable 2'b10 (executed-fetch mode) fires on a program-bus transaction with `pab_fetch_i`=1, `pab_first_i`=1, `pab_exec_i`=1 and a matching address.
- R3: In executed-fetch mode, none of the following fires: a fetch with `pab_first_i`=0 (second word), a fetch with `pab_exec_i`=0 (killed fetch or untaken jump), a program-bus data read or write, or any data-bus access.
- R4: Selection 2'b01 (program-bus mode) with any nonzero enable fires on every program fetch at the matching address, including killed fetches and second words.
- R5: In program-bus mode, a non-fetch transaction with `pab_write_i`=1 fires for enable 2'b01 and 2'b11. A non-fetch transaction with `pab_write_i`=0 fires for enable 2'b10 and 2'b11. Data-bus accesses never fire in this mode.
- R6: Selection 2'b10 (data-bus mode) fires on a first-data-bus access with `xa_write_i`=1 for enable 2'b01 and 2'b11, and with `xa_write_i`=0 for enable 2'b10 and 2'b11. Program-bus transactions never fire in this mode.
- R7: The reserved combinations never fire: selection 2'b11 with any enable, and selection 2'b00 with enable 2'b01 or 2'b11.
- R8: The address match is an exact AW-bit equality between the bus address and `bp_addr_i`. A difference in any single bit, including the MSB and the LSB, blocks the trigger.
- R9: `trig_o` is registered. It rises in the cycle after the qualifying transaction and stays high for one cycle only, unless another qualifying transaction follows.
- R10: While `rst_n` is low, `trig_o` is 0. Reset acts asynchronously on the trigger register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Selection field: bus and access class |
| en_i | input | 2 | Enable field: 00 off, 01 write, 10 read, 11 both |
| bp_addr_i | input | AW | Breakpoint address register |
| pab_valid_i | input | 1 | Program-bus transaction present this cycle |
| pab_addr_i | input | AW | Program-bus address |
| pab_fetch_i | input | 1 | Transaction is an instruction fetch |
| pab_first_i | input | 1 | Fetch is the first word of an instruction |
| pab_exec_i | input | 1 | Fetched instruction executes (not killed, not an untaken jump) |
| pab_write_i | input | 1 | Program-memory write (data move into program memory) |
| xa_valid_i | input | 1 | First data-bus access present this cycle |
| xa_addr_i | input | AW | First data-bus address |
| xa_write_i | input | 1 | First data-bus access is a write |
| trig_o | output | 1 | Registered breakpoint trigger pulse |
| glob_en_o | output | 1 | Global enable for all other comparators |

## Verification
Both buses can carry a transaction at the breakpoint address in the same cycle. Only the bus picked by the selection field may count. The bench builds vectors in which a matching fetch and a matching data access share one cycle. It checks that executed-fetch mode fires because of the fetch, and that data-bus mode fires because of the data access. Other vectors present a matching access on the bus that is not selected, with the selected bus idle or mismatched, and expect no trigger.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        SEL_EXEC_FETCH = 2'b00,
        SEL_PROG_BUS   = 2'b01,
        SEL_DATA_BUS   = 2'b10,
        SEL_RESERVED   = 2'b11
    } bkpt_sel_e;

    // Which transaction classes are armed in the current mode
    typedef struct packed {
        logic exec_fetch;  // first word of an executed instruction only
        logic any_fetch;   // every program fetch
        logic p_rd;        // program-bus non-fetch read
        logic p_wr;        // program-bus write
        logic d_rd;        // data bus read
        logic d_wr;        // data bus write
    } bkpt_watch_t;

    typedef struct packed {
        logic trig;
    } bkpt_state_t;

    localparam int unsigned NBUS = 2;
    localparam int unsigned BUS_PROG = 0;
    localparam int unsigned BUS_DATA = 1;

endpackage

// File: rtl/bkpt_mode_decode.sv
module bkpt_mode_decode
    import bkpt_pkg::*;
(
    input  logic [1:0]  sel_i,
    input  logic [1:0]  en_i,
    output bkpt_watch_t watch_o,
    output logic        any_en_o
);

    always_comb begin
        watch_o  = '0;
        any_en_o = (en_i != 2'b00);
        if (any_en_o) begin
            unique case (bkpt_sel_e'(sel_i))
                SEL_EXEC_FETCH: begin
                    // only enable 10 is defined here
                    watch_o.exec_fetch = (en_i == 2'b10);
                end
                SEL_PROG_BUS: begin
                    watch_o.any_fetch = 1'b1;
                    watch_o.p_wr      = en_i[0];
                    watch_o.p_rd      = en_i[1];
                end
                SEL_DATA_BUS: begin
                    watch_o.d_wr = en_i[0];
                    watch_o.d_rd = en_i[1];
                end
                default: begin
                    watch_o = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
    parameter int unsigned AW = 16
) (
    input  logic          valid_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] ref_i,
    output logic          hit_o
);

    always_comb begin
        hit_o = valid_i && (addr_i == ref_i);
    end

endmodule

// File: rtl/bkpt_qualifier.sv
module bkpt_qualifier
    import bkpt_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel_i,
    input  logic [1:0]    en_i,
    input  logic [AW-1:0] bp_addr_i,
    input  logic          pab_valid_i,
    input  logic [AW-1:0] pab_addr_i,
    input  logic          pab_fetch_i,
    input  logic          pab_first_i,
    input  logic          pab_exec_i,
    input  logic          pab_write_i,
    input  logic          xa_valid_i,
    input  logic [AW-1:0] xa_addr_i,
    input  logic          xa_write_i,
    output logic          trig_o,
    output logic          glob_en_o
);

    bkpt_watch_t watch;
    logic        any_en;
    logic [AW-1:0] bus_addr [NBUS];
    logic [NBUS-1:0] bus_valid;
    logic [NBUS-1:0] bus_hit;
    bkpt_state_t st_d, st_q;

    bkpt_mode_decode u_dec (
        .sel_i    (sel_i),
        .en_i     (en_i),
        .watch_o  (watch),
        .any_en_o (any_en)
    );

    always_comb begin
        bus_addr[BUS_PROG]  = pab_addr_i;
        bus_addr[BUS_DATA]  = xa_addr_i;
        bus_valid[BUS_PROG] = pab_valid_i;
        bus_valid[BUS_DATA] = xa_valid_i;
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_cmp
        bkpt_addr_cmp #(.AW(AW)) u_cmp (
            .valid_i (bus_valid[b]),
            .addr_i  (bus_addr[b]),
            .ref_i   (bp_addr_i),
            .hit_o   (bus_hit[b])
        );
    end

    always_comb begin
        logic p_ok;
        logic d_ok;
        p_ok = (watch.exec_fetch && pab_fetch_i && pab_first_i && pab_exec_i)
             || (watch.any_fetch && pab_fetch_i)
             || (watch.p_rd && !pab_fetch_i && !pab_write_i)
             || (watch.p_wr && !pab_fetch_i && pab_write_i);
        d_ok = (watch.d_rd && !xa_write_i) || (watch.d_wr && xa_write_i);
        st_d      = st_q;
        st_d.trig = (bus_hit[BUS_PROG] && p_ok) || (bus_hit[BUS_DATA] && d_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o    = st_q.trig;
    assign glob_en_o = any_en;

endmodule

// File: rtl/bkpt_qualifier_chk.sv
module bkpt_qualifier_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    sel_i,
    input logic [1:0]    en_i,
    input logic [AW-1:0] bp_addr_i,
    input logic          pab_valid_i,
    input logic [AW-1:0] pab_addr_i,
    input logic          pab_fetch_i,
    input logic          pab_first_i,
    input logic          pab_exec_i,
    input logic          xa_valid_i,
    input logic [AW-1:0] xa_addr_i,
    input logic          trig_o
);

    // R1
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == 2'b00) |=> !trig_o);

    // R7
    rsvd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b11) |=> !trig_o);

    // R3
    fetch_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b00 && (!pab_valid_i || !pab_fetch_i || !pab_first_i || !pab_exec_i))
        |=> !trig_o);

    // R6
    data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b10 && !xa_valid_i) |=> !trig_o);

    // R8
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pab_addr_i != bp_addr_i && xa_addr_i != bp_addr_i) |=> !trig_o);

    // R9
    trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(pab_valid_i || xa_valid_i));

endmodule

bind bkpt_qualifier bkpt_qualifier_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel_i),
    .en_i        (en_i),
    .bp_addr_i   (bp_addr_i),
    .pab_valid_i (pab_valid_i),
    .pab_addr_i  (pab_addr_i),
    .pab_fetch_i (pab_fetch_i),
    .pab_first_i (pab_first_i),
    .pab_exec_i  (pab_exec_i),
    .xa_valid_i  (xa_valid_i),
    .xa_addr_i   (xa_addr_i),
    .trig_o      (trig_o)
);

// File: tb/sim_bkpt_qualifier.sv
module sim_bkpt_qualifier;

    localparam int unsigned AW = 16;
    localparam time PERIOD = 10ns;
    localparam logic [AW-1:0] BP = 16'h1234;

    // {sel[2], en[2], pv, pf, p1, px, pw, pm, xv, xw, xm, exp, req[4]}
    localparam int NV = 30;
    localparam logic [17:0] VEC [NV] = '{
        18'b00_10_111101_000_1_0010, // R2 executed first-word fetch
        18'b00_10_111100_000_0_1000, // R8 fetch at wrong address
        18'b00_10_110101_000_0_0011, // R3 second word
        18'b00_10_111001_000_0_0011, // R3 killed fetch
        18'b00_10_100001_000_0_0011, // R3 program-bus read
        18'b00_10_000000_101_0_0011, // R3 data-bus read
        18'b00_00_111101_000_0_0001, // R1 disabled
        18'b00_01_111101_000_0_0111, // R7 reserved
        18'b00_11_111101_000_0_0111, // R7 reserved
        18'b11_11_111101_101_0_0111, // R7 reserved selection
        18'b11_01_100011_111_0_0111, // R7 reserved selection
        18'b01_01_110001_000_1_0100, // R4 killed second-word fetch
        18'b01_10_110101_000_1_0100, // R4 second word
        18'b01_01_100011_000_1_0101, // R5 program write
        18'b01_01_100001_000_0_0101, // R5 read under write enable
        18'b01_10_100001_000_1_0101, // R5 program read
        18'b01_10_100011_000_0_0101, // R5 write under read enable
        18'b01_11_100011_000_1_0101, // R5 write under both
        18'b01_11_100001_000_1_0101, // R5 read under both
        18'b01_11_000000_101_0_0101, // R5 data bus ignored
        18'b10_01_000000_111_1_0110, // R6 data write
        18'b10_01_000000_101_0_0110, // R6 read under write enable
        18'b10_10_000000_101_1_0110, // R6 data read
        18'b10_10_000000_111_0_0110, // R6 write under read enable
        18'b10_11_000000_111_1_0110, // R6 write under both
        18'b10_11_000000_100_0_1000, // R8 data read wrong address
        18'b10_11_111101_000_0_0110, // R6 program bus ignored
        18'b10_00_000000_111_0_0001, // R1 disabled
        18'b00_10_111101_111_1_0010, // R2 fetch plus data write same cycle
        18'b10_10_111101_101_1_0110  // R6 data read plus fetch same cycle
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sel = '0, en = '0;
    logic pv = 0, pf = 0, p1 = 0, px = 0, pw = 0, xv = 0, xw = 0;
    logic [AW-1:0] paddr = '0, xaddr = '0;
    logic trig, gen;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    bkpt_qualifier #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .en_i(en), .bp_addr_i(BP),
        .pab_valid_i(pv), .pab_addr_i(paddr), .pab_fetch_i(pf),
        .pab_first_i(p1), .pab_exec_i(px), .pab_write_i(pw),
        .xa_valid_i(xv), .xa_addr_i(xaddr), .xa_write_i(xw),
        .trig_o(trig), .glob_en_o(gen)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        pv = 0; pf = 0; p1 = 0; px = 0; pw = 0; xv = 0; xw = 0;
        paddr = '0; xaddr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk(trig, 1'b0, "R10 reset trig");
        chk(gen, 1'b0, "R1 glob_en with en=00");
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: drive at negedge, result registered at next posedge
        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            sel = v[17:16]; en = v[15:14];
            pv = v[13]; pf = v[12]; p1 = v[11]; px = v[10]; pw = v[9];
            paddr = v[8] ? BP : (BP ^ 16'h0001);
            xv = v[7]; xw = v[6];
            xaddr = v[5] ? BP : (BP ^ 16'h0001);
            #1;
            chk(gen, (v[15:14] != 2'b00), $sformatf("R1 glob_en vec %0d", i));
            @(posedge clk);
            @(negedge clk);
            chk(trig, v[4], $sformatf("R%0d vec %0d", v[3:0], i));
        end

        // R9: latency and single-cycle width
        idle(); sel = 2'b00; en = 2'b10; @(negedge clk);
        pv = 1; pf = 1; p1 = 1; px = 1; paddr = BP;
        #1 chk(trig, 1'b0, "R9 no same-cycle trigger");
        @(negedge clk);
        chk(trig, 1'b1, "R9 trigger next cycle");
        idle();
        @(negedge clk);
        chk(trig, 1'b0, "R9 pulse one cycle");

        // R8: MSB difference blocks
        pv = 1; pf = 1; p1 = 1; px = 1; paddr = BP ^ 16'h8000;
        @(negedge clk);
        chk(trig, 1'b0, "R8 msb mismatch");

        // R10: asynchronous reset clears a pending trigger
        paddr = BP;
        @(negedge clk);
        chk(trig, 1'b1, "R10 armed before reset");
        #(PERIOD/4) rst_n = 1'b0;
        #1 chk(trig, 1'b0, "R10 async clear");
        @(negedge clk);
        chk(trig, 1'b0, "R10 held in reset");
        rst_n = 1'b1;
        idle();
        @(negedge clk);
        finish_run();
    end

endmodule